// File: doc/BRIEF.md
# Multiplexed Address Latch and Chip-Select Decoder

This block sits between a processor that time-shares its upper address byte on a narrow multiplexed bus and a bank of up to four byte-wide memories. A latch-enable input marks the phase in which the upper address bits are on the bus. While it is high the block is transparent, and the value that was present at the last clock edge with the enable high is held after it drops. The held word is then decoded into four active-low chip selects and the high address pins that go to the memory devices. Tying the latch enable high turns the block into a plain combinational decoder for a bus that is not multiplexed.

A static size input selects whether the bank is built from 4K-byte or 2K-byte devices, which moves the chip-select field within the latched word. An active-low memory enable is driven for the bank. By default it also requires a read or write strobe. A build parameter drops the strobes from the enable for systems that gate the memories elsewhere.

The latched word carries address bits 8 to 13: `ma_in[0]` is address bit 8 and `ma_in[5]` is address bit 13. Chip select k is the one driven on `cs_n[k]`.

Top module: `madec_top`

## Requirements
- R1: After reset is released with `le` low, all of `cs_n` are high, `mem_en_n` is high and `a_hi` is zero, until `le` is raised.
- R2: While `le` is high, the outputs follow `ma_in` in the same cycle with no clock edge needed, so a permanently high `le` gives a pure decoder.
- R3: When `le` falls, the outputs keep the decode of the `ma_in` value sampled at the last rising clock edge at which `le` was high, and changes on `ma_in` while `le` stays low have no effect on any output.
- R4: With `mode_4k` = 1, latched bits [5:4] give the index k of the single low `cs_n[k]`, and `a_hi` equals latched bits [3:0].
- R5: With `mode_4k` = 0, latched bits [4:3] give the index k of the low `cs_n[k]`, `a_hi[2:0]` equals latched bits [2:0], and `a_hi[3]` is 0.
- R6: With `mode_4k` = 0 and latched bit 5 set, all of `cs_n` stay high and `mem_en_n` stays high whatever the strobes are.
- R7: At most one bit of `cs_n` is low at any time.
- R8: With `USE_STROBES` = 1, `mem_en_n` is low exactly when one bit of `cs_n` is low and at least one of `rd_n` or `wr_n` is low.
- R9: With `USE_STROBES` = 0, `mem_en_n` is low exactly when one bit of `cs_n` is low, whatever the strobes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the address while `le` is high |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| le | input | 1 | Latch enable: transparent when high, holding when low |
| ma_in | input | 6 | Multiplexed upper address bits 8 to 13 |
| rd_n | input | 1 | Active-low memory read strobe |
| wr_n | input | 1 | Active-low memory write strobe |
| mode_4k | input | 1 | Device size: 1 for 4K-byte, 0 for 2K-byte memories |
| cs_n | output | 4 | Active-low chip selects, one per memory device |
| mem_en_n | output | 1 | Active-low memory enable for the bank |
| a_hi | output | 4 | High address pins to the memories (address bits 8 to 11) |

## Verification
On every cycle the assertions check that no more than one chip select is low, that the enable never goes low without a selected device or, when strobes are in use, without a strobe, that the top pass-through pin stays low in 2K mode, that out-of-range addresses in 2K mode select nothing, and that the held word does not move while the latch enable stays low. Whether each address lands on the right device and the right high address pins in each size mode, and which sampled value survives the falling enable, can only be shown by the bench's scenarios, which compare every output against a model of the decode. The scenarios also cover the idle state after reset and the variant built without strobes.

// File: rtl/madec_pkg.sv
package madec_pkg;
  // Memory device size selected by the static mode input.
  typedef enum logic {
    SIZE_2K = 1'b0,
    SIZE_4K = 1'b1
  } mem_size_e;
endpackage

// File: rtl/madec_latch.sv
module madec_latch #(
  parameter int MA_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            le,
  input  logic [MA_W-1:0] ma_in,
  output logic [MA_W-1:0] lat_word,
  output logic            lat_ok
);
  logic [MA_W-1:0] held_q, held_d;
  logic            seen_q, seen_d;

  // Next state: sample while the enable is high, hold otherwise.
  always_comb begin
    held_d = held_q;
    seen_d = seen_q;
    if (le) begin
      held_d = ma_in;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      seen_q <= 1'b0;
    end else begin
      held_q <= held_d;
      seen_q <= seen_d;
    end
  end

  // Transparent path while enabled, stored word otherwise.
  always_comb begin
    lat_word = le ? ma_in : held_q;
    lat_ok   = le | seen_q;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && $past(!le)) |-> ($stable(lat_word) && $stable(lat_ok))) // R3
    else $error("latched word moved while enable low");
endmodule

// File: rtl/madec_decode.sv
module madec_decode
  import madec_pkg::*;
#(
  parameter int MA_W   = 6,
  parameter int NUM_CS = 4,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int A_W   = MA_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MA_W-1:0]   lat_word,
  input  logic              lat_ok,
  input  mem_size_e         size,
  output logic [NUM_CS-1:0] cs_act,
  output logic [A_W-1:0]    a_pass,
  output logic              hit
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    if (size == SIZE_4K) begin
      sel    = lat_word[MA_W-1 -: SEL_W];
      hit    = lat_ok;
      a_pass = lat_word[A_W-1:0];
    end else begin
      sel    = lat_word[MA_W-2 -: SEL_W];
      hit    = lat_ok && !lat_word[MA_W-1];
      a_pass = {1'b0, lat_word[A_W-2:0]};
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_act[g] = hit && (sel == SEL_W'(g));
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_act)) // R7
    else $error("more than one chip select active");

  AST_HIT_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(cs_act) == 1)) // R7
    else $error("decode hit without a chip select");
endmodule

// File: rtl/madec_enable.sv
module madec_enable #(
  parameter bit USE_STROBES = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rd_n,
  input  logic wr_n,
  output logic en_n
);
  if (USE_STROBES) begin : g_strobed
    always_comb en_n = !(hit && (!rd_n || !wr_n));

    AST_EN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_n |-> (!rd_n || !wr_n)) // R8
      else $error("enable without strobe");
  end else begin : g_plain
    always_comb en_n = !hit;

    AST_EN_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n) == hit) // R9
      else $error("enable differs from decode");
  end
endmodule

// File: rtl/madec_top.sv
module madec_top
  import madec_pkg::*;
#(
  parameter int MA_W        = 6,
  parameter int NUM_CS      = 4,
  parameter bit USE_STROBES = 1'b1,
  localparam int SEL_W      = $clog2(NUM_CS),
  localparam int A_W        = MA_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le,
  input  logic [MA_W-1:0]   ma_in,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              mode_4k,
  output logic [NUM_CS-1:0] cs_n,
  output logic              mem_en_n,
  output logic [A_W-1:0]    a_hi
);
  logic [MA_W-1:0]   lat_word;
  logic              lat_ok;
  logic [NUM_CS-1:0] cs_act;
  logic              hit;
  mem_size_e         size;

  always_comb size = mem_size_e'(mode_4k);

  madec_latch #(.MA_W(MA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .le       (le),
    .ma_in    (ma_in),
    .lat_word (lat_word),
    .lat_ok   (lat_ok)
  );

  madec_decode #(.MA_W(MA_W), .NUM_CS(NUM_CS)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_word (lat_word),
    .lat_ok   (lat_ok),
    .size     (size),
    .cs_act   (cs_act),
    .a_pass   (a_hi),
    .hit      (hit)
  );

  madec_enable #(.USE_STROBES(USE_STROBES)) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .en_n  (mem_en_n)
  );

  always_comb cs_n = ~cs_act;

  AST_EN_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_n |-> (cs_n != '1)) // R8
    else $error("memory enable with no chip select");

  AST_2K_TOP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_4k |-> !a_hi[A_W-1]) // R5
    else $error("top address pin driven in 2K mode");

  AST_2K_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !mode_4k && ma_in[MA_W-1]) |-> ((&cs_n) && mem_en_n)) // R6
    else $error("out-of-range 2K address selected a device");
endmodule

// File: tb/madec_top_tb.sv
module madec_top_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le = 1'b0;
  logic [5:0] ma_in = '0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       mode_4k = 1'b1;
  logic [3:0] cs_n, cs_n_ns;
  logic       mem_en_n, mem_en_n_ns;
  logic [3:0] a_hi, a_hi_ns;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  madec_top u_dut (
    .clk(clk), .rst_n(rst_n), .le(le), .ma_in(ma_in), .rd_n(rd_n), .wr_n(wr_n),
    .mode_4k(mode_4k), .cs_n(cs_n), .mem_en_n(mem_en_n), .a_hi(a_hi)
  );

  madec_top #(.USE_STROBES(1'b0)) u_dut_ns (
    .clk(clk), .rst_n(rst_n), .le(le), .ma_in(ma_in), .rd_n(rd_n), .wr_n(wr_n),
    .mode_4k(mode_4k), .cs_n(cs_n_ns), .mem_en_n(mem_en_n_ns), .a_hi(a_hi_ns)
  );

  // Reference decode: {cs_n, mem_en_n, a_hi}
  function automatic logic [8:0] model(logic [5:0] a, bit m4k, bit r_n, bit w_n,
                                       bit use_stb, bit ok);
    logic [1:0] s;
    logic       h;
    logic [3:0] p;
    logic [3:0] c;
    logic       e;
    if (m4k) begin s = a[5:4]; h = ok; p = a[3:0]; end
    else begin s = a[4:3]; h = ok && !a[5]; p = {1'b0, a[2:0]}; end
    c = 4'hF;
    if (h) c[s] = 1'b0;
    e = use_stb ? !(h && (!r_n || !w_n)) : !h;
    return {c, e, p};
  endfunction

  task automatic check(string req, logic [8:0] got, logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h (cs_n,en_n,a_hi) t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [8:0] out_s();
    return {cs_n, mem_en_n, a_hi};
  endfunction

  function automatic logic [8:0] out_ns();
    return {cs_n_ns, mem_en_n_ns, a_hi_ns};
  endfunction

  task automatic drive(bit l, logic [5:0] a, bit r, bit w, bit m);
    @(negedge clk);
    le = l; ma_in = a; rd_n = r; wr_n = w; mode_4k = m;
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; le = 1'b0; ma_in = 6'h2A; rd_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 idle after reset", out_s(), {4'hF, 1'b1, 4'h0});
    check("R1 idle after reset no-strobe", out_ns(), {4'hF, 1'b1, 4'h0});
    drive(0, 6'h15, 0, 0, 1);
    check("R1 input ignored before enable", out_s(), {4'hF, 1'b1, 4'h0});
  endtask

  task automatic t_transparent();
    logic [5:0] v [4] = '{6'h00, 6'h1B, 6'h27, 6'h3C};
    foreach (v[i]) begin
      drive(1, v[i], 0, 1, 1);
      check("R2 transparent follow", out_s(), model(v[i], 1, 0, 1, 1, 1));
    end
  endtask

  task automatic t_hold();
    drive(1, 6'h26, 1, 0, 1);
    drive(0, 6'h19, 1, 0, 1);
    check("R3 hold after fall", out_s(), model(6'h26, 1, 1, 0, 1, 1));
    drive(0, 6'h3F, 1, 0, 1);
    check("R3 input ignored while held", out_s(), model(6'h26, 1, 1, 0, 1, 1));
    drive(0, 6'h00, 1, 0, 1);
    check("R3 still held", out_s(), model(6'h26, 1, 1, 0, 1, 1));
  endtask

  task automatic t_dec4k();
    for (int i = 0; i < 64; i++) begin
      drive(1, 6'(i), 0, 1, 1);
      check("R4 4K decode", out_s(), model(6'(i), 1, 0, 1, 1, 1));
      n_chk++;
      if ($countones(~cs_n) > 1) begin
        n_bad++;
        $display("FAIL R7 low selects=%0d exp<=1", $countones(~cs_n));
      end
    end
  endtask

  task automatic t_dec2k();
    for (int i = 0; i < 64; i++) begin
      drive(1, 6'(i), 1, 0, 0);
      if (i >= 32)
        check("R6 2K out of range", out_s(), {4'hF, 1'b1, 1'b0, 3'(i)});
      else
        check("R5 2K decode", out_s(), model(6'(i), 0, 1, 0, 1, 1));
    end
    drive(1, 6'h2C, 1, 0, 0);
    drive(0, 6'h0C, 0, 0, 0);
    check("R6 held out of range stays idle", out_s(), {4'hF, 1'b1, 4'h4});
  endtask

  task automatic t_strobes();
    for (int k = 0; k < 4; k++) begin
      drive(1, 6'h31, k[0], k[1], 1);
      check("R8 strobe gating", out_s(), model(6'h31, 1, k[0], k[1], 1, 1));
    end
  endtask

  task automatic t_nostrobe();
    for (int k = 0; k < 4; k++) begin
      drive(1, 6'h12, k[0], k[1], 1);
      check("R9 no-strobe enable", out_ns(), model(6'h12, 1, k[0], k[1], 0, 1));
    end
    drive(1, 6'h22, 0, 0, 0);
    check("R9 no-strobe 2K miss", out_ns(), {4'hF, 1'b1, 4'h2});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_transparent();
    t_hold();
    t_dec4k();
    t_dec2k();
    t_strobes();
    t_nostrobe();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule